// File: doc/BRIEF.md
# Quadword Add/Subtract Execution Unit

This block is a pipelined execution slice for a vector unit. It takes two or three 128-bit operands and performs one of eight unsigned integer operations on them. The operations are addition or subtraction, each in four forms: a plain modulo result, an extended form that adds a carry-in, a form that returns only the carry out, and an extended form that returns only the carry out. The extended forms read their carry-in from bit 0 of the third operand C and ignore the rest of C. A carry-only form returns a full 128-bit word whose value is 0 or 1.

The datapath splits into two 64-bit halves. The first stage adds the low halves and registers the low sum, its carry and the high operand halves. The second stage adds the high halves with that carry, picks the full sum or the carry word, and registers the result. A new operation can enter on every clock. Each result comes out exactly two cycles after its operands.

Top module: `qw_addsub_unit`

## Requirements
- R1: `in_op` is a 3-bit code. Bit 2 set means subtract, bit 1 set means extended (carry-in from C), and bit 0 set means carry-write. All eight codes are legal.
- R2: Code 000 returns (A + B) mod 2^128.
- R3: Code 010 returns (A + B + C[0]) mod 2^128. Bits 127..1 of C have no effect on the result.
- R4: Code 100 returns (A - B) mod 2^128, formed as A + ~B + 1.
- R5: Code 110 returns (A + ~B + C[0]) mod 2^128. Bits 127..1 of C have no effect on the result.
- R6: For codes with bit 0 set, result bits 127..1 are zero. Result bit 0 is the carry out of bit 127 of the sum that the same code with bit 0 clear would form.
- R7: The carry of code 001 is 1 exactly when ~A < B as unsigned values. The carry of code 011 is also 1 when C[0] is 1 and A + B equals all ones.
- R8: The carry of code 101 is 1 exactly when A >= B as unsigned values, so 1 means no borrow. The carry of code 111 is 1 when A > B, or when C[0] is 1 and A == B.
- R9: `out_valid` is high in the cycle two clocks after `in_valid` was sampled high, and operations may be issued back to back. A synchronous reset clears both pipeline valid bits, so `out_valid` is low in the first cycle after reset.
- R10: A carry out of the low 64 bits propagates into the high half. For example, A with its low 64 bits all ones plus B = 1 produces 1 at bit 64 and clears the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and code are presented this cycle |
| in_op | input | 3 | Operation code (subtract, extended, carry-write) |
| in_a | input | 128 | First operand |
| in_b | input | 128 | Second operand |
| in_c | input | 128 | Carry source; only bit 0 is used |
| out_valid | output | 1 | Result is valid this cycle |
| out_result | output | 128 | Sum, difference, or 0/1 carry word |

## Verification
The assertions check on every cycle that results follow operands by exactly two clocks and that reset empties the pipeline. They also check that every carry-write result has zero in its upper 127 bits. For the plain add, plain subtract, extended add and the two non-extended carry codes, they recompute the expected value from the port inputs two cycles earlier. The bench's scenarios are needed for the rest: the extended subtract codes, the effect of C[0] against bits of C that must be ignored, the propagation of a carry across the 64-bit boundary, and a reset that arrives while the pipeline is full. The bench covers these with a 129-bit reference model, directed corner operands (zeros, all ones, equal operands, a low half of all ones) and random traffic with bubbles.

// File: rtl/qw_pkg.sv
package qw_pkg;

  localparam int OP_W = 3;

  // Field order matches the code bits: [2] subtract, [1] extended, [0] carry-write
  typedef struct packed {
    logic sub;
    logic ext;
    logic cw;
  } qw_op_t;

  function automatic qw_op_t decode_op(input logic [OP_W-1:0] code);
    return qw_op_t'(code);
  endfunction

  // Carry into bit 0: extended forms take C[0]; otherwise subtract needs the +1
  function automatic logic carry_seed(input qw_op_t op, input logic c0);
    return op.ext ? c0 : op.sub;
  endfunction

endpackage

// File: rtl/qw_operand_prep.sv
module qw_operand_prep
  import qw_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] b_in,
  input  logic              c_bit0,
  output qw_op_t            op,
  output logic [DATA_W-1:0] b_eff,
  output logic              cin
);

  assign op  = decode_op(op_code);
  assign cin = carry_seed(op, c_bit0);

  // Conditional one's complement of B, one lane per bit
  for (genvar i = 0; i < DATA_W; i++) begin : g_inv
    assign b_eff[i] = b_in[i] ^ op.sub;
  end

endmodule

// File: rtl/qw_low_stage.sv
module qw_low_stage
  import qw_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  qw_op_t            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b_eff,
  input  logic              cin,
  output logic              s1_valid,
  output qw_op_t            s1_op,
  output logic [HALF_W-1:0] s1_lo_sum,
  output logic              s1_lo_cout,
  output logic [DATA_W-HALF_W-1:0] s1_a_hi,
  output logic [DATA_W-HALF_W-1:0] s1_b_hi
);

  localparam int HI_W = DATA_W - HALF_W;

  function automatic logic [HALF_W:0] add_lo(input logic [HALF_W-1:0] x,
                                             input logic [HALF_W-1:0] y,
                                             input logic ci);
    return {1'b0, x} + {1'b0, y} + {{HALF_W{1'b0}}, ci};
  endfunction

  logic [HALF_W:0] lo_full;
  assign lo_full = add_lo(a[HALF_W-1:0], b_eff[HALF_W-1:0], cin);

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_op      <= op;
      s1_lo_sum  <= lo_full[HALF_W-1:0];
      s1_lo_cout <= lo_full[HALF_W];
      s1_a_hi    <= a[DATA_W-1:HALF_W];
      s1_b_hi    <= b_eff[DATA_W-1:HALF_W];
    end
  end

  logic unused_hi_w;
  assign unused_hi_w = (HI_W == 0);

endmodule

// File: rtl/qw_high_stage.sv
module qw_high_stage
  import qw_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  qw_op_t            s1_op,
  input  logic [HALF_W-1:0] s1_lo_sum,
  input  logic              s1_lo_cout,
  input  logic [DATA_W-HALF_W-1:0] s1_a_hi,
  input  logic [DATA_W-HALF_W-1:0] s1_b_hi,
  output logic              hi_cout,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);

  localparam int HI_W = DATA_W - HALF_W;

  function automatic logic [HI_W:0] add_hi(input logic [HI_W-1:0] x,
                                           input logic [HI_W-1:0] y,
                                           input logic ci);
    return {1'b0, x} + {1'b0, y} + {{HI_W{1'b0}}, ci};
  endfunction

  function automatic logic [DATA_W-1:0] pick(input qw_op_t op,
                                             input logic [DATA_W-1:0] sum,
                                             input logic carry);
    return op.cw ? {{(DATA_W-1){1'b0}}, carry} : sum;
  endfunction

  logic [HI_W:0]     hi_full;
  logic [DATA_W-1:0] full_sum;

  assign hi_full  = add_hi(s1_a_hi, s1_b_hi, s1_lo_cout);
  assign hi_cout  = hi_full[HI_W];
  assign full_sum = {hi_full[HI_W-1:0], s1_lo_sum};

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) out_result <= pick(s1_op, full_sum, hi_cout);
  end

endmodule

// File: rtl/qw_addsub_unit.sv
module qw_addsub_unit
  import qw_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_c,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);

  localparam int HI_W = DATA_W - HALF_W;

  qw_op_t            op_dec;
  logic [DATA_W-1:0] b_eff;
  logic              cin;

  // Named internal events for the checker
  logic              st1_valid;
  qw_op_t            st1_op;
  logic [HALF_W-1:0] st1_lo_sum;
  logic              st1_lo_cout;
  logic [HI_W-1:0]   st1_a_hi;
  logic [HI_W-1:0]   st1_b_hi;
  logic              st2_carry;

  qw_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .op_code (in_op),
    .b_in    (in_b),
    .c_bit0  (in_c[0]),
    .op      (op_dec),
    .b_eff   (b_eff),
    .cin     (cin)
  );

  qw_low_stage #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_lo (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op         (op_dec),
    .a          (in_a),
    .b_eff      (b_eff),
    .cin        (cin),
    .s1_valid   (st1_valid),
    .s1_op      (st1_op),
    .s1_lo_sum  (st1_lo_sum),
    .s1_lo_cout (st1_lo_cout),
    .s1_a_hi    (st1_a_hi),
    .s1_b_hi    (st1_b_hi)
  );

  qw_high_stage #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_hi (
    .clk        (clk),
    .rst        (rst),
    .s1_valid   (st1_valid),
    .s1_op      (st1_op),
    .s1_lo_sum  (st1_lo_sum),
    .s1_lo_cout (st1_lo_cout),
    .s1_a_hi    (st1_a_hi),
    .s1_b_hi    (st1_b_hi),
    .hi_cout    (st2_carry),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

endmodule

// File: rtl/qw_addsub_chk.sv
module qw_addsub_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_op,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [DATA_W-1:0] in_c,
  input logic              st1_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result
);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_reset_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd0) |-> (!out_valid && !st1_valid));

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_cw_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_op[0], 2)) |-> (out_result[DATA_W-1:1] == '0));

  p_mod_add_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_op, 2) == 3'b000)
      |-> (out_result == $past(in_a, 2) + $past(in_b, 2)));

  p_ext_add_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_op, 2) == 3'b010)
      |-> (out_result == $past(in_a, 2) + $past(in_b, 2)
                         + {{(DATA_W-1){1'b0}}, $past(in_c[0], 2)}));

  p_mod_sub_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_op, 2) == 3'b100)
      |-> (out_result == $past(in_a, 2) - $past(in_b, 2)));

  p_add_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_op, 2) == 3'b001)
      |-> (out_result[0] == ($past(~in_a, 2) < $past(in_b, 2))));

  p_sub_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_op, 2) == 3'b101)
      |-> (out_result[0] == ($past(in_a, 2) >= $past(in_b, 2))));

endmodule

bind qw_addsub_unit qw_addsub_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_a       (in_a),
  .in_b       (in_b),
  .in_c       (in_c),
  .st1_valid  (st1_valid),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/sim_qw_addsub_unit.sv
module sim_qw_addsub_unit;

  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   in_op = '0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [W-1:0] in_c = '0;
  logic         out_valid;
  logic [W-1:0] out_result;

  int total = 0;
  int bad   = 0;

  typedef struct {
    bit           v;
    logic [2:0]   op;
    logic [W-1:0] r;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  qw_addsub_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_result(out_result)
  );

  // Reference: add with a 129-bit sum, subtract with a 129-bit borrow
  function automatic logic [W-1:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [W-1:0] c);
    logic [W:0] t;
    logic       carry;
    if (!op[2]) begin
      t = {1'b0, a} + {1'b0, b} + ((op[1] && c[0]) ? (W+1)'(1) : (W+1)'(0));
      carry = t[W];
    end else begin
      t = {1'b0, a} - {1'b0, b} - ((op[1] && !c[0]) ? (W+1)'(1) : (W+1)'(0));
      carry = !t[W];
    end
    return op[0] ? W'(carry) : t[W-1:0];
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1 R2";
      3'd1: return "R6 R7";
      3'd2: return "R1 R3";
      3'd3: return "R6 R7";
      3'd4: return "R1 R4 R10";
      3'd5: return "R6 R8";
      3'd6: return "R1 R5";
      default: return "R6 R8";
    endcase
  endfunction

  function automatic logic [W-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check_out();
    exp_t e;
    e = q.pop_front();
    total++;
    if (out_valid !== e.v) begin
      bad++;
      $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, e.v);
    end else if (e.v && out_result !== e.r) begin
      bad++;
      $display("FAIL %s op=%0d actual=%h expected=%h", tag(e.op), e.op, out_result, e.r);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] op, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [W-1:0] c);
    exp_t e;
    @(negedge clk);
    check_out();
    in_valid = v; in_op = op; in_a = a; in_b = b; in_c = c;
    e.v = v; e.op = op; e.r = model(op, a, b, c);
    q.push_back(e);
  endtask

  task automatic do_reset();
    exp_t e;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    q.delete();
    e.v = 1'b0; e.op = '0; e.r = '0;
    q.push_back(e); q.push_back(e);   // R9: pipeline must read empty after reset
  endtask

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] LO_ONES = {{(W/2){1'b0}}, {(W/2){1'b1}}};
  localparam logic [W-1:0] C_HI_ONLY = {{(W-1){1'b1}}, 1'b0};

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] va [8];
    logic [W-1:0] vb [8];
    logic [W-1:0] x;
    do_reset();
    x = rnd128();
    va[0] = '0;      vb[0] = '0;
    va[1] = ONES;    vb[1] = ONES;
    va[2] = x;       vb[2] = x;          // A == B
    va[3] = LO_ONES; vb[3] = W'(1);      // R10 low-to-high carry
    va[4] = ONES;    vb[4] = '0;
    va[5] = '0;      vb[5] = ONES;
    va[6] = x;       vb[6] = ~x;         // A + B all ones
    va[7] = W'(5);   vb[7] = W'(9);      // A < B
    // R1: every code over every corner pair, with C = 0, 1, upper-only, all ones
    for (int i = 0; i < 8; i++)
      for (int op = 0; op < 8; op++) begin
        step(1'b1, 3'(op), va[i], vb[i], '0);
        step(1'b1, 3'(op), va[i], vb[i], W'(1));
        step(1'b1, 3'(op), va[i], vb[i], C_HI_ONLY);   // R3 R5 upper C ignored
        step(1'b1, 3'(op), va[i], vb[i], ONES);
      end
    // R9: reset while the pipeline is full
    step(1'b1, 3'd0, rnd128(), rnd128(), '0);
    step(1'b1, 3'd4, rnd128(), rnd128(), '0);
    do_reset();
    // Random traffic with bubbles
    for (int n = 0; n < 1500; n++)
      step(($urandom % 4) != 0, 3'($urandom), rnd128(), rnd128(), rnd128());
    step(1'b0, '0, '0, '0, '0);
    step(1'b0, '0, '0, '0, '0);
    step(1'b0, '0, '0, '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule